// File: doc/BRIEF.md
# Host Command Mailbox

A register-mapped mailbox through which a host processor hands commands to an embedded management controller. The host sees a small address window on a plain register bus: a command register that accepts a command word, a status register, an outbound data buffer it fills before issuing a command, and an inbound buffer from which it collects response data. A command write latches the word, marks the mailbox busy and rings a one-cycle doorbell toward the controller.

The controller sees the latched command word and the whole outbound buffer as flat vectors. It deposits response words into the inbound buffer, then strobes done with an error flag, an 8-bit error code and its own initiator id. Busy then drops. If the command asked for completion notification, the host also gets a one-cycle interrupt pulse that needs no acknowledge. The host normally polls busy and then inspects the error bit.

Top module: `hmb_mailbox`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0, all outbound and inbound words are 0, and neither the doorbell nor the host interrupt is high.
- R2: A host write to offset 0x00 while idle latches the 32-bit word on cmd_word_o. From the next cycle the status busy bit (bit 0) reads 1, and doorbell_o is high for exactly one cycle.
- R3: A host write to offset 0x00 while busy is ignored: cmd_word_o keeps its value and no doorbell pulse follows.
- R4: done_i sampled while busy clears busy from the next cycle. The status then holds the error flag in bit 1, the initiator id in bits [15:8] and the error code in bits [23:16]. Bits [7:4] echo the command id, which is bits [15:12] of the latched command word.
- R5: When done is taken, host_irq_o pulses high for exactly one cycle in the cycle after, if and only if bit 8 (ioc) of the latched command word is set.
- R6: A host write to 0x80 + 4k while idle updates outbound word k (obuf_o bits [32k+31:32k]). Writes to the outbound buffer while busy are ignored.
- R7: The controller writes inbound word k with rsp_we_i. A host read at 0x90 + 4k with rd_byte_i low returns the word. With rd_byte_i high, the read returns byte addr[1:0] of that word (little-endian lanes), zero-extended.
- R8: Reads of the write-only locations, offset 0x00 and 0x80 to 0x8F, return 0.
- R9: Host writes to the status register or the inbound buffer leave the read values of both unchanged.
- R10: An accepted command clears the error bit, error code and initiator id fields of the status.
- R11: done_i while idle has no effect: the status is unchanged and no host interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Host byte address |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 32 | Host write data |
| rd_byte_i | input | 1 | Host read of a single inbound byte |
| rdata_o | output | 32 | Host read data (combinational from addr_i) |
| host_irq_o | output | 1 | Completion pulse to host |
| doorbell_o | output | 1 | New-command pulse to controller |
| cmd_word_o | output | 32 | Latched command word |
| obuf_o | output | 128 | Outbound buffer, word k in bits [32k+31:32k] |
| done_i | input | 1 | Controller completion strobe |
| err_i | input | 1 | Controller error flag, valid with done_i |
| err_code_i | input | 8 | Controller error code, valid with done_i |
| init_id_i | input | 8 | Controller initiator id, valid with done_i |
| rsp_we_i | input | 1 | Controller inbound word write |
| rsp_idx_i | input | 2 | Inbound word index |
| rsp_word_i | input | 32 | Inbound word data |

## Verification
The embedded properties check every cycle that an accepted command raises busy and a doorbell at once, that the doorbell never lasts two cycles, and that the command word and outbound buffer stay still while busy. They also check that done while busy releases busy, that an interrupt only follows a done on an ioc command, and that a stray done never produces one. The bench sweeps all command ids with ioc on and off and both error outcomes. Only these scenarios show the field placement in the status word, the byte-lane mapping of inbound reads, the zero reads of write-only space, and the clearing of stale error fields by a new command.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_OBUF = 'h80;
  localparam int OFF_IBUF = 'h90;
  localparam int IOC_BIT  = 8;
  localparam int CID_LSB  = 12;

  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] err_code;
    logic [7:0] init_id;
    logic [3:0] cid;
    logic [1:0] rsvd_lo;
    logic       err;
    logic       busy;
  } hmb_status_t;
endpackage

// File: rtl/hmb_cmd_ctrl.sv
module hmb_cmd_ctrl
  import hmb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [7:0]  err_code_i,
  input  logic [7:0]  init_id_i,
  output logic        busy_o,
  output logic        doorbell_o,
  output logic        irq_o,
  output logic [31:0] cmd_word_o,
  output hmb_status_t status_o
);
  logic        busy_q, db_q, irq_q, err_q;
  logic [31:0] cmd_q;
  logic [7:0]  code_q, iid_q;
  logic        accept, finish;

  assign accept = cmd_we_i && !busy_q;
  assign finish = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      cmd_q  <= '0;
      code_q <= '0;
      iid_q  <= '0;
    end else begin
      db_q  <= accept;
      irq_q <= finish && cmd_q[IOC_BIT];
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= wdata_i;
        err_q  <= 1'b0;
        code_q <= '0;
        iid_q  <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= err_code_i;
        iid_q  <= init_id_i;
      end
    end
  end

  assign busy_o     = busy_q;
  assign doorbell_o = db_q;
  assign irq_o      = irq_q;
  assign cmd_word_o = cmd_q;

  always_comb begin
    status_o          = '0;
    status_o.busy     = busy_q;
    status_o.err      = err_q;
    status_o.cid      = cmd_q[CID_LSB +: 4];
    status_o.init_id  = iid_q;
    status_o.err_code = code_q;
  end

  p_accept_rings_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o) |=> (doorbell_o && busy_o && cmd_word_o == $past(wdata_i)));
  p_doorbell_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_o |=> !doorbell_o);
  p_busy_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy_o) |=> ($stable(cmd_word_o) && !doorbell_o));
  p_done_releases_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_o) |=> !busy_o);
  p_irq_needs_ioc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(done_i && busy_o && cmd_word_o[IOC_BIT]));
  p_idle_done_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_o && !cmd_we_i) |=> (!irq_o && $stable(status_o)));
endmodule

// File: rtl/hmb_obuf.sv
module hmb_obuf #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                freeze_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [31:0]         wdata_i,
  output logic [WORDS*32-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           word_q <= '0;
      else if (we_i && !freeze_i && idx_i == IDX_W'(g))      word_q <= wdata_i;
    end
    assign words_o[g*32 +: 32] = word_q;
  end

  p_obuf_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(words_o));
endmodule

// File: rtl/hmb_ibuf.sv
module hmb_ibuf #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_word_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [1:0]       rd_lane_i,
  input  logic             rd_byte_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (wr_i && wr_idx_i == IDX_W'(g))    mem_q[g] <= wr_word_i;
    end
  end

  logic [31:0] word;
  assign word    = mem_q[rd_idx_i];
  assign rdata_o = rd_byte_i ? {24'h0, word[8*rd_lane_i +: 8]} : word;

  p_rsp_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mem_q[$past(wr_idx_i)] == $past(wr_word_i));
endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
  import hmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OBUF_WORDS = 4,
  parameter int IBUF_WORDS = 4,
  localparam int OB_IDX_W = $clog2(OBUF_WORDS),
  localparam int IB_IDX_W = $clog2(IBUF_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_en_i,
  input  logic [31:0]              wdata_i,
  input  logic                     rd_byte_i,
  output logic [31:0]              rdata_o,
  output logic                     host_irq_o,
  output logic                     doorbell_o,
  output logic [31:0]              cmd_word_o,
  output logic [OBUF_WORDS*32-1:0] obuf_o,
  input  logic                     done_i,
  input  logic                     err_i,
  input  logic [7:0]               err_code_i,
  input  logic [7:0]               init_id_i,
  input  logic                     rsp_we_i,
  input  logic [IB_IDX_W-1:0]      rsp_idx_i,
  input  logic [31:0]              rsp_word_i
);
  localparam int OB_TAG_W = ADDR_W - OB_IDX_W - 2;
  localparam int IB_TAG_W = ADDR_W - IB_IDX_W - 2;

  // buffers are decoded by tag, so each base is aligned to its own size
  logic cmd_hit, stat_hit, obuf_hit, ibuf_hit;
  assign cmd_hit  = addr_i == ADDR_W'(OFF_CMD);
  assign stat_hit = addr_i == ADDR_W'(OFF_STAT);
  assign obuf_hit = addr_i[ADDR_W-1 -: OB_TAG_W] == OB_TAG_W'(OFF_OBUF >> (OB_IDX_W + 2));
  assign ibuf_hit = addr_i[ADDR_W-1 -: IB_TAG_W] == IB_TAG_W'(OFF_IBUF >> (IB_IDX_W + 2));

  logic        busy;
  hmb_status_t status;
  logic [31:0] ibuf_rdata;

  hmb_cmd_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (wr_en_i && cmd_hit),
    .wdata_i    (wdata_i),
    .done_i     (done_i),
    .err_i      (err_i),
    .err_code_i (err_code_i),
    .init_id_i  (init_id_i),
    .busy_o     (busy),
    .doorbell_o (doorbell_o),
    .irq_o      (host_irq_o),
    .cmd_word_o (cmd_word_o),
    .status_o   (status)
  );

  hmb_obuf #(.WORDS(OBUF_WORDS)) u_obuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i && obuf_hit),
    .freeze_i (busy),
    .idx_i    (addr_i[OB_IDX_W+1:2]),
    .wdata_i  (wdata_i),
    .words_o  (obuf_o)
  );

  hmb_ibuf #(.WORDS(IBUF_WORDS)) u_ibuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (rsp_we_i),
    .wr_idx_i  (rsp_idx_i),
    .wr_word_i (rsp_word_i),
    .rd_idx_i  (addr_i[IB_IDX_W+1:2]),
    .rd_lane_i (addr_i[1:0]),
    .rd_byte_i (rd_byte_i),
    .rdata_o   (ibuf_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (stat_hit)      rdata_o = status;
    else if (ibuf_hit) rdata_o = ibuf_rdata;
  end

  p_wo_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit || obuf_hit) |-> rdata_o == '0);
endmodule

// File: tb/hmb_mailbox_test.sv
`timescale 1ns/1ps
module hmb_mailbox_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic         wr = 1'b0;
  logic [31:0]  wdata = '0;
  logic         rd_byte = 1'b0;
  logic [31:0]  rdata;
  logic         irq, db;
  logic [31:0]  cmd_word;
  logic [127:0] obuf;
  logic         done = 1'b0, err = 1'b0;
  logic [7:0]   code = '0, iid = '0;
  logic         rsp_we = 1'b0;
  logic [1:0]   rsp_idx = '0;
  logic [31:0]  rsp_word = '0;

  int checks = 0, fails = 0, db_cnt = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  hmb_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rd_byte_i(rd_byte), .rdata_o(rdata), .host_irq_o(irq), .doorbell_o(db),
    .cmd_word_o(cmd_word), .obuf_o(obuf), .done_i(done), .err_i(err),
    .err_code_i(code), .init_id_i(iid), .rsp_we_i(rsp_we), .rsp_idx_i(rsp_idx),
    .rsp_word_i(rsp_word)
  );

  always @(negedge clk) begin
    if (db)  db_cnt++;
    if (irq) irq_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk); addr = a; rd_byte = b;
    #1 d = rdata;
    rd_byte = 1'b0;
  endtask

  task automatic ctl_done(input logic e, input logic [7:0] c, input logic [7:0] i);
    @(negedge clk); done = 1'b1; err = e; code = c; iid = i;
    @(negedge clk); done = 1'b0; err = 1'b0; code = '0; iid = '0;
  endtask

  task automatic ctl_rsp(input logic [1:0] k, input logic [31:0] w);
    @(negedge clk); rsp_we = 1'b1; rsp_idx = k; rsp_word = w;
    @(negedge clk); rsp_we = 1'b0;
  endtask

  function automatic logic [31:0] stat_of(input logic [7:0] c, input logic [7:0] i,
                                          input logic [3:0] cid, input logic e, input logic b);
    return {8'h00, c, i, cid, 2'b00, e, b};
  endfunction

  function automatic logic [31:0] rsp_pat(input int k);
    return 32'h1F2E3D4C ^ (32'h01030507 * (k + 1));
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, st, w, ow;
    int db0, irq0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    host_rd(8'h04, 1'b0, d); check("R1 status", d, 32'h0);
    check("R1 obuf", obuf[31:0] | obuf[63:32] | obuf[95:64] | obuf[127:96], 32'h0);
    for (int k = 0; k < 4; k++) begin
      host_rd(8'h90 + 8'(4*k), 1'b0, d); check("R1 ibuf", d, 32'h0);
    end
    check("R1 doorbell", 32'(db_cnt), 32'h0);
    check("R1 irq", 32'(irq_cnt), 32'h0);

    // R11 stray done while idle
    ctl_done(1'b1, 8'h5A, 8'h33);
    repeat (2) @(negedge clk);
    host_rd(8'h04, 1'b0, d); check("R11 status", d, 32'h0);
    check("R11 irq", 32'(irq_cnt), 32'h0);

    // R7 inbound word and byte sweep
    for (int k = 0; k < 4; k++) ctl_rsp(2'(k), rsp_pat(k));
    for (int k = 0; k < 4; k++) begin
      host_rd(8'h90 + 8'(4*k), 1'b0, d); check("R7 word", d, rsp_pat(k));
      for (int b = 0; b < 4; b++) begin
        w = rsp_pat(k);
        host_rd(8'h90 + 8'(4*k + b), 1'b1, d);
        check("R7 byte", d, (w >> (8*b)) & 32'hFF);
      end
    end

    // R9 writes to read-only space
    host_wr(8'h04, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) host_wr(8'h90 + 8'(4*k), 32'hDEAD_BEEF);
    host_rd(8'h04, 1'b0, d); check("R9 status", d, 32'h0);
    for (int k = 0; k < 4; k++) begin
      host_rd(8'h90 + 8'(4*k), 1'b0, d); check("R9 ibuf", d, rsp_pat(k));
    end

    // sweep every command id with ioc on and off
    st = 32'h0;
    for (int cid = 0; cid < 16; cid++) begin
      for (int ioc = 0; ioc < 2; ioc++) begin
        logic [31:0] cmd;
        logic        e;
        logic [7:0]  c, i;
        int          wk;
        cmd = {8'h00, 8'(cid*3), 4'(cid), 3'b000, 1'(ioc), 8'hF0 | 8'(cid)};
        e   = 1'(cid) ^ 1'(ioc);
        c   = 8'(cid*16 + ioc + 1);
        i   = 8'(8'hC0 + cid);
        wk  = cid % 4;
        ow  = {8'(cid), 8'(ioc), 16'hA55A};

        // R6 idle outbound write
        host_wr(8'h80 + 8'(4*wk), ow);
        check("R6 obuf idle write", obuf[32*wk +: 32], ow);

        db0 = db_cnt; irq0 = irq_cnt;
        host_wr(8'h00, cmd);
        check("R2 cmd latched", cmd_word, cmd);
        host_rd(8'h04, 1'b0, d);
        check("R2 R10 status after accept", d, stat_of(8'h0, 8'h0, 4'(cid), 1'b0, 1'b1));
        check("R2 doorbell count", 32'(db_cnt - db0), 32'h1);

        // R3 command write while busy
        host_wr(8'h00, ~cmd);
        @(negedge clk);
        check("R3 cmd unchanged", cmd_word, cmd);
        check("R3 no doorbell", 32'(db_cnt - db0), 32'h1);

        // R6 outbound frozen while busy
        host_wr(8'h80 + 8'(4*wk), ~ow);
        check("R6 obuf frozen", obuf[32*wk +: 32], ow);

        // R8 write-only reads
        host_rd(8'h00, 1'b0, d); check("R8 cmd reads zero", d, 32'h0);
        host_rd(8'h80 + 8'(4*wk), 1'b0, d); check("R8 obuf reads zero", d, 32'h0);

        ctl_done(e, c, i);
        @(negedge clk);
        host_rd(8'h04, 1'b0, d);
        check("R4 status after done", d, stat_of(c, i, 4'(cid), e, 1'b0));
        check("R5 irq count", 32'(irq_cnt - irq0), 32'(ioc));
        st = d;
      end
    end

    // R11 stray done after completion leaves status
    irq0 = irq_cnt;
    ctl_done(1'b0, 8'h11, 8'h22);
    repeat (2) @(negedge clk);
    host_rd(8'h04, 1'b0, d); check("R11 status kept", d, st);
    check("R11 no irq", 32'(irq_cnt - irq0), 32'h0);

    finish_run();
  end
endmodule